// File: doc/BRIEF.md
# Hardwired Accumulator Processor with Two-Bit Phase Control

This block is a small stored-program processor built around a single 16-bit accumulator. An instruction word has a 6-bit operation code in its upper bits and a 10-bit word address in its lower bits. It executes five operations: load, store, add, unconditional jump and jump-if-not-negative. Program and data share one 1024-word by 16-bit memory.

Every instruction takes exactly four clock cycles. Control is hardwired. Two flip-flops step through four phases in Gray order: address set, fetch, decode, execute. The execute phase is shared by all operations. The actual action is chosen there by comparing the operation code, which stays in the instruction register from fetch onward. The memory is written so that it can map onto a dual-port block RAM.

A second memory port is there for the surrounding test logic. While reset is held it preloads program and data words, and at any time it reads any word back. The architectural registers and the phase are driven straight out as observation ports.

Top module: `acc_cpu`

## Requirements
- R1: While `rst` is high at a rising edge, the phase becomes 00 and the accumulator, instruction register, program counter and memory address register all become zero; memory contents are kept.
- R2: Out of reset the phase steps 00 → 01 → 11 → 10 → 00 on successive edges, one instruction per four cycles.
- R3: In phase 00 the address register takes the program counter and the program counter increments modulo 1024 (0x3FF wraps to 0).
- R4: In phase 01 the instruction register takes the word at the address register; in phase 11 the address register takes instruction bits [9:0]; the instruction register changes in no other phase.
- R5: In phase 10 with operation code (bits [15:10]) equal to 4, the accumulator takes the memory word at the address field.
- R6: Operation code 8 writes the accumulator to the memory word at the address field.
- R7: Operation code 16 adds the memory word to the accumulator modulo 2^16 (carry out dropped, 0xFFFF + 1 = 0).
- R8: Operation code 32 loads the program counter with the address field.
- R9: Operation code 33 loads the program counter with the address field only when accumulator bit 15 is 0; otherwise the program counter keeps its incremented value.
- R10: Any other operation code changes no register and no memory word, and the next instruction follows in sequence. The accumulator changes only under codes 4 and 16.
- R11: The preload port writes `ld_data` to `ld_addr` only when `ld_en` and `rst` are both high. `obs_data` shows the word at `obs_addr` one cycle after that address is presented. The processor does not write memory while `rst` is high.
- R12: The program 0x1003, 0x4004, 0x2005 at words 0 to 2, with 7 at word 3 and 9 at word 4, leaves 16 in word 5 after three instructions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset; also enables preload |
| ld_en | input | 1 | Preload write strobe (used only while `rst` is high) |
| ld_addr | input | 10 | Preload word address |
| ld_data | input | 16 | Preload word |
| obs_addr | input | 10 | Observation read address |
| obs_data | output | 16 | Word read at `obs_addr`, one cycle later |
| phase_o | output | 2 | Current phase code |
| acc_o | output | 16 | Accumulator |
| ir_o | output | 16 | Instruction register |
| iar_o | output | 10 | Program counter |
| mar_o | output | 10 | Memory address register |

## Verification
The hardest conditions to reach from the ports are a conditional jump evaluated against a negative accumulator and the program counter rolling over from 0x3FF to 0. Both need a specific sequence of earlier instructions before the machine is in that state. A directed program gets there in order. It loads 0xFFFF and adds 1 to reach zero with a wrap, jumps on the non-negative result, then loads 0x8000 so the next conditional jump falls through. It then meets an undefined code and a store, and finally makes an unconditional jump to 0x3FF whose fall-through address wraps. A seeded random program mixing all codes with undefined ones follows, and its stores are checked by reading memory back under reset.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  // Gray-ordered phase codes; the order is behaviour.
  typedef enum logic [1:0] {
    PH_ADDR   = 2'b00,
    PH_FETCH  = 2'b01,
    PH_DECODE = 2'b11,
    PH_EXEC   = 2'b10
  } phase_t;

  localparam int OPC_W = 6;

  localparam logic [OPC_W-1:0] OPC_LOAD  = 6'd4;
  localparam logic [OPC_W-1:0] OPC_STORE = 6'd8;
  localparam logic [OPC_W-1:0] OPC_ADD   = 6'd16;
  localparam logic [OPC_W-1:0] OPC_JUMP  = 6'd32;
  localparam logic [OPC_W-1:0] OPC_JPOS  = 6'd33;

endpackage

// File: rtl/acc_phase_seq.sv
module acc_phase_seq
  import acc_cpu_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  output phase_t phase
);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_ADDR;
    end else begin
      unique case (phase)
        PH_ADDR:   phase <= PH_FETCH;
        PH_FETCH:  phase <= PH_DECODE;
        PH_DECODE: phase <= PH_EXEC;
        PH_EXEC:   phase <= PH_ADDR;
        default:   phase <= PH_ADDR;
      endcase
    end
  end

endmodule

// File: rtl/acc_ripple_add.sv
module acc_ripple_add #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum
);

  // carry[i] is the carry into bit i; the carry out of the top bit is never formed.
  logic [W-1:0] carry;

  assign carry[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign sum[i] = a[i] ^ b[i] ^ carry[i];
    if (i < W - 1) begin : g_carry
      assign carry[i+1] = (a[i] & b[i]) | (a[i] & carry[i]) | (b[i] & carry[i]);
    end
  end

endmodule

// File: rtl/acc_word_ram.sv
module acc_word_ram #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic              a_we,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic              b_we,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Two ports, registered read, old data returned on a same-address write.
  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wdata;
    if (b_we) mem[b_addr] <= b_wdata;
    a_rdata <= mem[a_addr];
    b_rdata <= mem[b_addr];
  end

endmodule

// File: rtl/acc_datapath.sv
module acc_datapath
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  phase_t            phase,
  input  logic [DATA_W-1:0] rd_word,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [DATA_W-1:0] acc,
  output logic [DATA_W-1:0] ir,
  output logic [ADDR_W-1:0] iar,
  output logic [ADDR_W-1:0] mar
);

  localparam int OPW = DATA_W - ADDR_W;

  logic [OPW-1:0]    opc;
  logic [ADDR_W-1:0] afield;
  logic [DATA_W-1:0] sum;

  assign opc    = ir[DATA_W-1:ADDR_W];
  assign afield = ir[ADDR_W-1:0];

  acc_ripple_add #(.W(DATA_W)) u_add (
    .a   (acc),
    .b   (rd_word),
    .sum (sum)
  );

  // The RAM read is registered, so the address is steered one phase early:
  // program counter in address set (word used in fetch), address field in
  // decode (word used in execute). In execute the field equals MAR.
  assign mem_addr  = (phase == PH_ADDR) ? iar : afield;
  assign mem_we    = !rst && (phase == PH_EXEC) && (opc == OPW'(OPC_STORE));
  assign mem_wdata = acc;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0;
      ir  <= '0;
      iar <= '0;
      mar <= '0;
    end else begin
      unique case (phase)
        PH_ADDR: begin
          mar <= iar;
          iar <= iar + ADDR_W'(1);
        end
        PH_FETCH: begin
          ir <= rd_word;
        end
        PH_DECODE: begin
          mar <= afield;
        end
        PH_EXEC: begin
          if (opc == OPW'(OPC_LOAD)) acc <= rd_word;
          if (opc == OPW'(OPC_ADD))  acc <= sum;
          if (opc == OPW'(OPC_JUMP)) iar <= afield;
          if (opc == OPW'(OPC_JPOS) && !acc[DATA_W-1]) iar <= afield;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_en,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [DATA_W-1:0] ld_data,
  input  logic [ADDR_W-1:0] obs_addr,
  output logic [DATA_W-1:0] obs_data,
  output logic [1:0]        phase_o,
  output logic [DATA_W-1:0] acc_o,
  output logic [DATA_W-1:0] ir_o,
  output logic [ADDR_W-1:0] iar_o,
  output logic [ADDR_W-1:0] mar_o
);

  phase_t            phase;
  logic [ADDR_W-1:0] cpu_addr;
  logic              cpu_we;
  logic [DATA_W-1:0] cpu_wdata;
  logic [DATA_W-1:0] cpu_rdata;
  logic              pre_we;
  logic [ADDR_W-1:0] side_addr;

  acc_phase_seq u_seq (
    .clk   (clk),
    .rst   (rst),
    .phase (phase)
  );

  acc_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .phase     (phase),
    .rd_word   (cpu_rdata),
    .mem_addr  (cpu_addr),
    .mem_we    (cpu_we),
    .mem_wdata (cpu_wdata),
    .acc       (acc_o),
    .ir        (ir_o),
    .iar       (iar_o),
    .mar       (mar_o)
  );

  assign pre_we    = ld_en && rst;
  assign side_addr = pre_we ? ld_addr : obs_addr;

  acc_word_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .clk     (clk),
    .a_addr  (cpu_addr),
    .a_we    (cpu_we),
    .a_wdata (cpu_wdata),
    .a_rdata (cpu_rdata),
    .b_addr  (side_addr),
    .b_we    (pre_we),
    .b_wdata (ld_data),
    .b_rdata (obs_data)
  );

  assign phase_o = phase;

endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        phase_o,
  input logic [DATA_W-1:0] acc_o,
  input logic [DATA_W-1:0] ir_o,
  input logic [ADDR_W-1:0] iar_o,
  input logic [ADDR_W-1:0] mar_o
);

  localparam int OPW = DATA_W - ADDR_W;

  logic [OPW-1:0] opc;
  assign opc = ir_o[DATA_W-1:ADDR_W];

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (phase_o == 2'b00 && acc_o == '0 && ir_o == '0 && iar_o == '0 && mar_o == '0));

  assert_addr_to_fetch_R2: assert property (@(posedge clk) disable iff (rst)
    phase_o == 2'b00 |=> phase_o == 2'b01);

  assert_exec_to_addr_R2: assert property (@(posedge clk) disable iff (rst)
    phase_o == 2'b10 |=> phase_o == 2'b00);

  assert_addr_set_R3: assert property (@(posedge clk) disable iff (rst)
    phase_o == 2'b00 |=> (mar_o == $past(iar_o) && iar_o == ADDR_W'($past(iar_o) + 1'b1)));

  assert_decode_mar_R4: assert property (@(posedge clk) disable iff (rst)
    phase_o == 2'b11 |=> mar_o == $past(ir_o[ADDR_W-1:0]));

  assert_ir_hold_R4: assert property (@(posedge clk) disable iff (rst)
    phase_o != 2'b01 |=> $stable(ir_o));

  assert_acc_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (phase_o != 2'b10 || (opc != OPW'(OPC_LOAD) && opc != OPW'(OPC_ADD))) |=> $stable(acc_o));

  assert_jump_R8: assert property (@(posedge clk) disable iff (rst)
    (phase_o == 2'b10 && opc == OPW'(OPC_JUMP)) |=> iar_o == $past(ir_o[ADDR_W-1:0]));

  assert_jpos_neg_R9: assert property (@(posedge clk) disable iff (rst)
    (phase_o == 2'b10 && opc == OPW'(OPC_JPOS) && acc_o[DATA_W-1]) |=> $stable(iar_o));

endmodule

bind acc_cpu acc_cpu_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .phase_o (phase_o),
  .acc_o   (acc_o),
  .ir_o    (ir_o),
  .iar_o   (iar_o),
  .mar_o   (mar_o)
);

// File: tb/acc_cpu_tb.sv
module acc_cpu_tb;

  localparam int CLK_P = 10;
  localparam int SEED  = 20240611;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_en = 1'b0;
  logic [9:0]  ld_addr = '0;
  logic [15:0] ld_data = '0;
  logic [9:0]  obs_addr = '0;
  logic [15:0] obs_data;
  logic [1:0]  phase_o;
  logic [15:0] acc_o, ir_o;
  logic [9:0]  iar_o, mar_o;

  always #(CLK_P/2) clk = ~clk;

  acc_cpu u_dut (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
    .obs_addr(obs_addr), .obs_data(obs_data), .phase_o(phase_o),
    .acc_o(acc_o), .ir_o(ir_o), .iar_o(iar_o), .mar_o(mar_o)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [15:0] m [1024];
  logic [15:0] e_acc, e_ir;
  logic [9:0]  e_iar, e_mar;

  function automatic logic [15:0] add16(input logic [15:0] a, input logic [15:0] b);
    logic [16:0] t;
    t = {1'b0, a} + {1'b0, b};
    return t[15:0];
  endfunction

  function automatic string op_tag(input logic [5:0] o);
    case (o)
      6'd4:    return "R5";
      6'd8:    return "R6";
      6'd16:   return "R7";
      6'd32:   return "R8";
      6'd33:   return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic model_step(output logic [5:0] opc);
    logic [15:0] w;
    w = m[e_iar];
    e_iar = e_iar + 10'd1;
    e_ir  = w;
    e_mar = w[9:0];
    opc   = w[15:10];
    case (opc)
      6'd4:  e_acc = m[e_mar];
      6'd8:  m[e_mar] = e_acc;
      6'd16: e_acc = add16(e_acc, m[e_mar]);
      6'd32: e_iar = w[9:0];
      6'd33: if (!e_acc[15]) e_iar = w[9:0];
      default: ;
    endcase
  endtask

  // Hold reset, preload all words from m, then check the cleared registers.
  task automatic reset_and_load();
    @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < 1024; i++) begin
      @(negedge clk);
      ld_en = 1'b1; ld_addr = 10'(i); ld_data = m[i];
    end
    @(negedge clk);
    ld_en = 1'b0;
    e_acc = '0; e_ir = '0; e_iar = '0; e_mar = '0;
    chk("R1", "phase", 32'(phase_o), 32'd0);
    chk("R1", "acc", 32'(acc_o), 32'd0);
    chk("R1", "ir", 32'(ir_o), 32'd0);
    chk("R1", "iar", 32'(iar_o), 32'd0);
    chk("R1", "mar", 32'(mar_o), 32'd0);
    rst = 1'b0;
  endtask

  task automatic run_instr(input int n, input bit trace, input int poke_at);
    logic [1:0] seq [4];
    logic [5:0] opc;
    seq[0] = 2'b01; seq[1] = 2'b11; seq[2] = 2'b10; seq[3] = 2'b00;
    for (int k = 0; k < n; k++) begin
      for (int c = 0; c < 4; c++) begin
        @(negedge clk);
        if (trace) chk("R2", "phase", 32'(phase_o), 32'(seq[c]));
        if (k == poke_at && c == 0) begin
          ld_en = 1'b1; ld_addr = 10'd1000; ld_data = 16'hBEEF;
        end else begin
          ld_en = 1'b0;
        end
      end
      model_step(opc);
      chk("R2", "phase at boundary", 32'(phase_o), 32'd0);
      chk(op_tag(opc), "acc", 32'(acc_o), 32'(e_acc));
      chk("R4", "ir", 32'(ir_o), 32'(e_ir));
      chk("R4", "mar", 32'(mar_o), 32'(e_mar));
      chk((opc == 6'd32 || opc == 6'd33) ? op_tag(opc) : "R3", "iar", 32'(iar_o), 32'(e_iar));
    end
  endtask

  task automatic mem_check(input int lo, input int hi, input string tag);
    @(negedge clk);
    rst = 1'b1;
    for (int a = lo; a <= hi; a++) begin
      obs_addr = 10'(a);
      @(negedge clk);
      chk(tag, "memory word", 32'(obs_data), 32'(m[a]));
    end
  endtask

  task automatic clear_image();
    for (int i = 0; i < 1024; i++) m[i] = '0;
  endtask

  initial begin
    void'($urandom(SEED));

    // Directed: sample program (R12)
    clear_image();
    m[0] = 16'h1003; m[1] = 16'h4004; m[2] = 16'h2005; m[3] = 16'd7; m[4] = 16'd9;
    reset_and_load();
    run_instr(1, 1'b1, -1);
    run_instr(2, 1'b0, -1);
    mem_check(5, 5, "R12");
    chk("R12", "word 5 literal", 32'(obs_data), 32'd16);
    mem_check(0, 4, "R11");

    // Directed corners: add wrap, both jump outcomes, undefined code, store,
    // jump to 0x3FF and counter wrap, preload strobe ignored out of reset.
    clear_image();
    m[0]  = 16'h1032; m[50] = 16'hFFFF;
    m[1]  = 16'h4033; m[51] = 16'h0001;
    m[2]  = 16'h8414;
    m[20] = 16'h1034; m[52] = 16'h8000;
    m[21] = 16'h841E;
    m[22] = 16'hFC05;
    m[23] = 16'h2035;
    m[24] = 16'h83FF;
    m[10'h3FF] = 16'h4033;
    reset_and_load();
    run_instr(10, 1'b0, 3);
    mem_check(50, 53, "R6");
    mem_check(1000, 1000, "R11");
    mem_check(5, 5, "R10");

    // Seeded random program mixing all codes with undefined ones.
    for (int pass = 0; pass < 2; pass++) begin
      clear_image();
      for (int i = 0; i < 64; i++) begin
        logic [5:0] o;
        case ($urandom % 7)
          0: o = 6'd4;
          1: o = 6'd8;
          2: o = 6'd16;
          3: o = 6'd32;
          4: o = 6'd33;
          default: o = 6'($urandom);
        endcase
        m[i] = {o, 10'($urandom % 64)};
      end
      reset_and_load();
      run_instr(150, 1'b0, -1);
      mem_check(0, 63, "R6");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      errors++;
      $display("FAIL R2 watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule